// File: doc/BRIEF.md
# Latched Secondary Interrupt Controller

This block collects a bank of peripheral interrupt sources and combines them into one upstream interrupt request for a first-level controller. Each source has a bit position in every register. A compile-time parameter selects one of two variants. The edge variant samples each source, detects rising edges, and holds them in a sticky pending register. Software acknowledges a pending bit by writing a one to that bit of a clear register. The level variant reports the sampled source levels directly and has no clear register.

Software controls masking through two strobe registers. One disables sources and the other enables them. A third register shows the current mask. There is no register that writes the mask directly. The upstream request is high while any source is both pending and enabled. A status read ignores the mask, so software must combine status with the mask status itself before it dispatches handlers.

The register port is a simple request interface with valid, write, address and write-data signals. Every read request receives its data on a registered response one cycle later.

Top module: `latched_irq_agg`

## Requirements
- R1: After reset the mask is all ones (every source disabled), every status bit is zero and `irq_o` is low.
- R2: Edge variant: a 0-to-1 transition on a source sets its status bit at offset 0x00. The bit stays set after the source falls. A disabled source still sets its bit.
- R3: Edge variant: writing to offset 0x08 clears each status bit whose write-data bit is 1. Bits written as 0 leave the status unchanged.
- R4: Edge variant: if a rising edge of a source is latched in the same cycle as a clear of that bit, the bit remains set.
- R5: Writing to the disable strobe (offset 0x10 in the edge variant, 0x08 in the level variant) sets the mask bits that are written as 1 and leaves the other mask bits unchanged.
- R6: Writing to the enable strobe (offset 0x14 in the edge variant, 0x0C in the level variant) clears the mask bits that are written as 1 and leaves the other mask bits unchanged.
- R7: The mask is read at offset 0x0C in the edge variant and at 0x04 in the level variant. A read of either strobe offset also returns the current mask.
- R8: `irq_o` is high exactly when the bitwise AND of status with the inverted mask is nonzero.
- R9: A status read returns every status bit, whether or not that source is masked.
- R10: Level variant: the status at offset 0x00 equals the source levels sampled one clock earlier, with no latching. The variant has no clear register: offset 0x08 there is the disable strobe.
- R11: Reads of offsets that have no register, and reads of the clear offset, return zero. Writes to offsets that have no register change nothing. The absent offsets are 0x04 and 0x18 in the edge variant, and 0x10 and 0x14 in the level variant.
- R12: Each read request accepted on a clock edge produces `rsp_valid_o` high with its data during the following cycle. No response appears without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Interrupt source lines |
| req_valid_i | input | 1 | Register request valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte offset of the register |
| req_wdata_i | input | DATA_W | Write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | DATA_W | Read data |
| irq_o | output | 1 | Upstream interrupt request |

## Verification
The bench builds two instances with 32 sources, a 32-bit data path and an 8-bit offset. One instance has EDGE_MODE=1 and the other has EDGE_MODE=0, so both register maps are exercised in the same run. With the edge instance the bench can time a source edge to land in the same cycle as an acknowledge, and can check that disabled sources still latch. With the level instance the bench can show that status follows the sources without latching, that the absent clear register leaves only the disable strobe at 0x08, and that the absent offsets ignore writes.

// File: rtl/lic_pkg.sv
package lic_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_ACK,
    SEL_MASK_VIEW,
    SEL_MASK_ON,
    SEL_MASK_OFF
  } lic_sel_e;

  localparam int EDGE_OFF_STATUS    = 'h00;
  localparam int EDGE_OFF_ACK       = 'h08;
  localparam int EDGE_OFF_MASK_VIEW = 'h0C;
  localparam int EDGE_OFF_MASK_ON   = 'h10;
  localparam int EDGE_OFF_MASK_OFF  = 'h14;

  localparam int LVL_OFF_STATUS     = 'h00;
  localparam int LVL_OFF_MASK_VIEW  = 'h04;
  localparam int LVL_OFF_MASK_ON    = 'h08;
  localparam int LVL_OFF_MASK_OFF   = 'h0C;

endpackage

// File: rtl/lic_sampler.sv
module lic_sampler #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  output logic [NUM_SRC-1:0] samp_o,
  output logic [NUM_SRC-1:0] rise_o
);

  logic [NUM_SRC-1:0] samp_q;
  logic [NUM_SRC-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= '0;
      prev_q <= '0;
    end else begin
      samp_q <= src_i;
      prev_q <= samp_q;
    end
  end

  assign samp_o = samp_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_edge
    assign rise_o[i] = samp_q[i] & ~prev_q[i];
  end

endmodule

// File: rtl/lic_status.sv
module lic_status #(
  parameter int NUM_SRC   = 32,
  parameter bit EDGE_MODE = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] samp_i,
  input  logic [NUM_SRC-1:0] rise_i,
  input  logic [NUM_SRC-1:0] ack_i,
  output logic [NUM_SRC-1:0] status_o
);

  // An edge arriving together with an acknowledge wins.
  function automatic logic [NUM_SRC-1:0] pend_next(
    input logic [NUM_SRC-1:0] cur,
    input logic [NUM_SRC-1:0] rise,
    input logic [NUM_SRC-1:0] ack
  );
    return (cur & ~ack) | rise;
  endfunction

  if (EDGE_MODE) begin : g_latched
    logic [NUM_SRC-1:0] pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= pend_next(pend_q, rise_i, ack_i);
    end

    assign status_o = pend_q;

    logic unused_samp;
    assign unused_samp = ^samp_i;

    AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_i != '0) |=> ((pend_q & $past(rise_i)) == $past(rise_i))); // R4

    AST_NO_SPURIOUS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q != '0) |-> ((pend_q & ~$past(pend_q) & ~$past(rise_i)) == '0)); // R2

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ((ack_i & ~rise_i) != '0) |=> ((pend_q & $past(ack_i & ~rise_i)) == '0)); // R3
  end else begin : g_live
    assign status_o = samp_i;

    logic unused_edge;
    assign unused_edge = ^{rise_i, ack_i};
  end

endmodule

// File: rtl/lic_mask.sv
module lic_mask #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] disable_i,
  input  logic [NUM_SRC-1:0] enable_i,
  output logic [NUM_SRC-1:0] mask_o
);

  function automatic logic [NUM_SRC-1:0] mask_next(
    input logic [NUM_SRC-1:0] cur,
    input logic [NUM_SRC-1:0] dis,
    input logic [NUM_SRC-1:0] ena
  );
    return (cur | dis) & ~ena;
  endfunction

  logic [NUM_SRC-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '1;
    else        mask_q <= mask_next(mask_q, disable_i, enable_i);
  end

  assign mask_o = mask_q;

  AST_DISABLE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (disable_i != '0) |=> ((mask_q & $past(disable_i)) == $past(disable_i))); // R5

  AST_ENABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i != '0) |=> ((mask_q & $past(enable_i)) == '0)); // R6

  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (disable_i == '0 && enable_i == '0) |=> $stable(mask_q)); // R5
endmodule

// File: rtl/lic_regs.sv
module lic_regs
  import lic_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  parameter bit EDGE_MODE = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid_i,
  input  logic               req_write_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [DATA_W-1:0]  req_wdata_i,
  input  logic [NUM_SRC-1:0] status_i,
  input  logic [NUM_SRC-1:0] mask_i,
  output logic [NUM_SRC-1:0] ack_o,
  output logic [NUM_SRC-1:0] disable_o,
  output logic [NUM_SRC-1:0] enable_o,
  output logic               rsp_valid_o,
  output logic [DATA_W-1:0]  rsp_rdata_o
);

  function automatic lic_sel_e decode(input logic [ADDR_W-1:0] a);
    lic_sel_e s;
    s = SEL_NONE;
    if (EDGE_MODE) begin
      if      (a == ADDR_W'(EDGE_OFF_STATUS))    s = SEL_STATUS;
      else if (a == ADDR_W'(EDGE_OFF_ACK))       s = SEL_ACK;
      else if (a == ADDR_W'(EDGE_OFF_MASK_VIEW)) s = SEL_MASK_VIEW;
      else if (a == ADDR_W'(EDGE_OFF_MASK_ON))   s = SEL_MASK_ON;
      else if (a == ADDR_W'(EDGE_OFF_MASK_OFF))  s = SEL_MASK_OFF;
    end else begin
      if      (a == ADDR_W'(LVL_OFF_STATUS))     s = SEL_STATUS;
      else if (a == ADDR_W'(LVL_OFF_MASK_VIEW))  s = SEL_MASK_VIEW;
      else if (a == ADDR_W'(LVL_OFF_MASK_ON))    s = SEL_MASK_ON;
      else if (a == ADDR_W'(LVL_OFF_MASK_OFF))   s = SEL_MASK_OFF;
    end
    return s;
  endfunction

  lic_sel_e           sel;
  logic               wr_fire;
  logic               rd_fire;
  logic [NUM_SRC-1:0] wbits;
  logic [DATA_W-1:0]  rd_mux;

  assign sel     = decode(req_addr_i);
  assign wr_fire = req_valid_i & req_write_i;
  assign rd_fire = req_valid_i & ~req_write_i;
  assign wbits   = req_wdata_i[NUM_SRC-1:0];

  assign ack_o     = (wr_fire && sel == SEL_ACK)      ? wbits : '0;
  assign disable_o = (wr_fire && sel == SEL_MASK_ON)  ? wbits : '0;
  assign enable_o  = (wr_fire && sel == SEL_MASK_OFF) ? wbits : '0;

  always_comb begin
    unique case (sel)
      SEL_STATUS:                            rd_mux = DATA_W'(status_i);
      SEL_MASK_VIEW, SEL_MASK_ON, SEL_MASK_OFF: rd_mux = DATA_W'(mask_i);
      default:                               rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= rd_fire;
      rsp_rdata_o <= rd_fire ? rd_mux : '0;
    end
  end

  AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rsp_valid_o); // R12

  AST_NO_STRAY_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> !rsp_valid_o); // R12

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ack_o != '0, disable_o != '0, enable_o != '0}) <= 1); // R11
endmodule

// File: rtl/latched_irq_agg.sv
module latched_irq_agg #(
  parameter int NUM_SRC   = 32,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  parameter bit EDGE_MODE = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               req_valid_i,
  input  logic               req_write_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [DATA_W-1:0]  req_wdata_i,
  output logic               rsp_valid_o,
  output logic [DATA_W-1:0]  rsp_rdata_o,
  output logic               irq_o
);

  function automatic logic any_live(
    input logic [NUM_SRC-1:0] st,
    input logic [NUM_SRC-1:0] mk
  );
    return |(st & ~mk);
  endfunction

  logic [NUM_SRC-1:0] samp_w, rise_w, status_w, mask_w;
  logic [NUM_SRC-1:0] ack_w, dis_w, ena_w;

  lic_sampler #(.NUM_SRC(NUM_SRC)) u_sampler (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .samp_o(samp_w), .rise_o(rise_w)
  );

  lic_status #(.NUM_SRC(NUM_SRC), .EDGE_MODE(EDGE_MODE)) u_status (
    .clk(clk), .rst_n(rst_n), .samp_i(samp_w), .rise_i(rise_w),
    .ack_i(ack_w), .status_o(status_w)
  );

  lic_mask #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk(clk), .rst_n(rst_n), .disable_i(dis_w), .enable_i(ena_w), .mask_o(mask_w)
  );

  lic_regs #(
    .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .EDGE_MODE(EDGE_MODE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid_i), .req_write_i(req_write_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .status_i(status_w), .mask_i(mask_w),
    .ack_o(ack_w), .disable_o(dis_w), .enable_o(ena_w),
    .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o)
  );

  assign irq_o = any_live(status_w, mask_w);

  AST_IRQ_NEEDS_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_w == '1) |-> !irq_o); // R8
endmodule

// File: tb/latched_irq_agg_tb.sv
module latched_irq_agg_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_e = '0, src_l = '0;
  logic        v_e = 1'b0, v_l = 1'b0, wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        rv_e, rv_l, irq_e, irq_l;
  logic [31:0] rd_e, rd_l;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] exp_e[$], exp_l[$];
  string       tag_e[$], tag_l[$];

  always #4 clk = ~clk;

  latched_irq_agg #(.EDGE_MODE(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src_e),
    .req_valid_i(v_e), .req_write_i(wr), .req_addr_i(addr), .req_wdata_i(wdata),
    .rsp_valid_o(rv_e), .rsp_rdata_o(rd_e), .irq_o(irq_e)
  );

  latched_irq_agg #(.EDGE_MODE(1'b0)) u_dut_lvl (
    .clk(clk), .rst_n(rst_n), .src_i(src_l),
    .req_valid_i(v_l), .req_write_i(wr), .req_addr_i(addr), .req_wdata_i(wdata),
    .rsp_valid_o(rv_l), .rsp_rdata_o(rd_l), .irq_o(irq_l)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard as responses come out.
  always @(negedge clk) begin
    if (rst_n && rv_e) begin
      if (exp_e.size() == 0) chk("R12 unexpected edge response", 32'h1, 32'h0);
      else chk(tag_e.pop_front(), rd_e, exp_e.pop_front());
    end
    if (rst_n && rv_l) begin
      if (exp_l.size() == 0) chk("R12 unexpected level response", 32'h1, 32'h0);
      else chk(tag_l.pop_front(), rd_l, exp_l.pop_front());
    end
  end

  task automatic wr_reg(input bit lvl, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    if (lvl) v_l = 1'b1; else v_e = 1'b1;
    @(negedge clk);
    v_e = 1'b0; v_l = 1'b0; wr = 1'b0;
  endtask

  task automatic rd_reg(input bit lvl, input logic [7:0] a, input logic [31:0] e,
                        input string tag);
    @(negedge clk);
    wr = 1'b0; addr = a;
    if (lvl) begin v_l = 1'b1; exp_l.push_back(e); tag_l.push_back(tag); end
    else     begin v_e = 1'b1; exp_e.push_back(e); tag_e.push_back(tag); end
    @(negedge clk);
    v_e = 1'b0; v_l = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // Edge variant
    chk("R1 irq after reset", {31'b0, irq_e}, 32'h0);
    rd_reg(0, 8'h00, 32'h0, "R1 pending after reset");
    rd_reg(0, 8'h0C, 32'hFFFF_FFFF, "R1 mask after reset");

    src_e = 32'h0000_0005; idle(3); src_e = '0; idle(2);
    rd_reg(0, 8'h00, 32'h0000_0005, "R2 masked edges latched and sticky");
    chk("R8 irq low while all masked", {31'b0, irq_e}, 32'h0);

    wr_reg(0, 8'h14, 32'h0000_0001);
    rd_reg(0, 8'h0C, 32'hFFFF_FFFE, "R6 enable bit0");
    chk("R8 irq high with enabled pending", {31'b0, irq_e}, 32'h1);
    rd_reg(0, 8'h10, 32'hFFFF_FFFE, "R7 mask via disable offset");
    rd_reg(0, 8'h14, 32'hFFFF_FFFE, "R7 mask via enable offset");
    rd_reg(0, 8'h00, 32'h0000_0005, "R9 status ignores mask");

    wr_reg(0, 8'h10, 32'h0000_0001);
    rd_reg(0, 8'h0C, 32'hFFFF_FFFF, "R5 disable bit0");
    chk("R8 irq low after disable", {31'b0, irq_e}, 32'h0);
    wr_reg(0, 8'h14, 32'h0000_0F0F);
    rd_reg(0, 8'h0C, 32'hFFFF_F0F0, "R6 enable pattern");
    wr_reg(0, 8'h10, 32'h0000_0003);
    rd_reg(0, 8'h0C, 32'hFFFF_F0F3, "R5 zero bits keep mask");
    chk("R8 irq from bit2", {31'b0, irq_e}, 32'h1);

    wr_reg(0, 8'h08, 32'h0000_0004);
    rd_reg(0, 8'h00, 32'h0000_0001, "R3 clear bit2");
    chk("R8 irq low, only masked bit0 pending", {31'b0, irq_e}, 32'h0);
    wr_reg(0, 8'h08, 32'h0);
    rd_reg(0, 8'h00, 32'h0000_0001, "R3 zero write keeps pending");

    src_e = 32'h0000_0020; idle(3); src_e = '0; idle(2);
    rd_reg(0, 8'h00, 32'h0000_0021, "R2 bit5 latched");
    @(negedge clk); src_e = 32'h0000_0020;
    wr_reg(0, 8'h08, 32'h0000_0020);   // ack lands on the edge-latch cycle
    rd_reg(0, 8'h00, 32'h0000_0021, "R4 edge beats clear");
    src_e = '0; idle(2);
    wr_reg(0, 8'h08, 32'h0000_0020);
    rd_reg(0, 8'h00, 32'h0000_0001, "R3 clear bit5 without edge");

    rd_reg(0, 8'h04, 32'h0, "R11 absent 0x04 reads zero");
    rd_reg(0, 8'h18, 32'h0, "R11 absent 0x18 reads zero");
    rd_reg(0, 8'h08, 32'h0, "R11 clear offset reads zero");
    wr_reg(0, 8'h04, 32'hFFFF_FFFF);
    wr_reg(0, 8'h18, 32'hFFFF_FFFF);
    rd_reg(0, 8'h0C, 32'hFFFF_F0F3, "R11 absent writes keep mask");
    rd_reg(0, 8'h00, 32'h0000_0001, "R11 absent writes keep pending");

    // Level variant
    rd_reg(1, 8'h04, 32'hFFFF_FFFF, "R1 level mask after reset");
    src_l = 32'h8000_0001; idle(2);
    rd_reg(1, 8'h00, 32'h8000_0001, "R10 status follows sources");
    chk("R8 level irq masked", {31'b0, irq_l}, 32'h0);
    wr_reg(1, 8'h0C, 32'h8000_0000);
    rd_reg(1, 8'h04, 32'h7FFF_FFFF, "R6 level enable bit31");
    chk("R8 level irq high", {31'b0, irq_l}, 32'h1);
    src_l = '0; idle(2);
    rd_reg(1, 8'h00, 32'h0, "R10 no latching in level variant");
    chk("R8 level irq drops with source", {31'b0, irq_l}, 32'h0);
    wr_reg(1, 8'h08, 32'h8000_0000);
    rd_reg(1, 8'h04, 32'hFFFF_FFFF, "R10 R5 0x08 is disable strobe");
    wr_reg(1, 8'h0C, 32'h0000_0003);
    wr_reg(1, 8'h10, 32'h0000_0003);
    wr_reg(1, 8'h14, 32'h0000_0003);
    rd_reg(1, 8'h04, 32'hFFFF_FFFC, "R11 level absent writes ignored");
    rd_reg(1, 8'h10, 32'h0, "R11 level absent 0x10 reads zero");
    rd_reg(1, 8'h14, 32'h0, "R11 level absent 0x14 reads zero");
    rd_reg(1, 8'h0C, 32'hFFFF_FFFC, "R7 level mask via enable offset");
    rd_reg(1, 8'h08, 32'hFFFF_FFFC, "R7 level mask via disable offset");

    idle(3);
    chk("R12 edge responses outstanding", exp_e.size(), 32'h0);
    chk("R12 level responses outstanding", exp_l.size(), 32'h0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule